// File: doc/BRIEF.md
# Palette-Mapped Gray-Scale Pixel Modulator

This block sits in the pixel path of a passive-matrix LCD controller. It turns frame-buffer pixel codes into a single on/off drive bit for each pixel. Each accepted code first selects one 4-bit level from a sixteen-entry palette. Software writes the palette as two 32-bit words. The level is then spread over a sixteen-phase duty cycle, so the slow response of the panel averages the pulses into a shade of gray.

The pixel depth can be 1, 2 or 4 bits. At the two lower depths the upper code bits are masked, so only the lowest palette entries are reachable. The frame-phase input comes from a counter outside the block that steps once per frame. The low four bits of the pixel's column index are added to that phase, so neighbouring pixels of the same level pulse in different frames. This reduces visible flicker. Inverting every palette entry produces reverse video without touching the frame buffer.

Top module: `gray_pwm`

## Requirements
- R1: Pixel code N reads palette entry N. Entries 0..7 live in word 0 (`reg_sel`=0) and entries 8..15 in word 1 (`reg_sel`=1). Entry N occupies bits [4*(N mod 8)+3 : 4*(N mod 8)] of its word.
- R2: `depth` = 0 keeps only code bit 0, `depth` = 1 keeps code bits 1:0, and `depth` = 2 or 3 uses all four code bits. Masked bits have no effect on the output.
- R3: After reset the palette is the identity map (entry N holds N), and `out_valid` and `out_bit` are 0.
- R4: Level 0 gives `out_bit` = 0 in every phase. Level 15 gives `out_bit` = 1 in every phase.
- R5: The on-count c(L) over the 16 phases is defined as follows:
  - c = L for levels 1..7;
  - c = L-1 for levels 8..14;
  - c = 0 for level 0;
  - c = 16 for level 15.
  Levels 7 and 8 therefore produce identical output.
- R6: The effective phase is p = (`frame_phase` + `pix_col`) mod 16. The bit is on when ((p*c) mod 16) + c >= 16, which spreads the c pulses evenly over the period.
- R7: The result for a pixel accepted at a rising edge (`pix_valid`=1) appears on `out_bit` with `out_valid`=1 after that edge, and only then.
- R8: A palette write at an edge applies to pixels accepted at later edges. A pixel accepted at the same edge as the write uses the old entry.
- R9: While no pixel is accepted, `out_valid` is 0 and `out_bit` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Palette word write enable |
| reg_sel | input | 1 | Palette word select (0: entries 0..7, 1: entries 8..15) |
| reg_wdata | input | 32 | Palette word write data |
| depth | input | 2 | Bits per pixel: 0 = 1, 1 = 2, 2/3 = 4 |
| frame_phase | input | 4 | Frame counter phase, steps once per frame |
| pix_valid | input | 1 | Pixel code strobe |
| pix_code | input | 4 | Frame-buffer pixel code |
| pix_col | input | 4 | Column index modulo 16 |
| out_valid | output | 1 | Drive bit valid |
| out_bit | output | 1 | Pixel on/off drive bit |

## Verification
The bench sweeps every level through all sixteen phases at column 0. A modulator that bunched its pulses or miscounted them would mismatch phase by phase. A design that kept levels 7 and 8 apart, or let level 15 drop a phase, would fail the R4/R5 items. It then walks the column offset and feeds 1- and 2-bit pixels with the upper code bits set under an inverted palette. An unmasked code would reach a far entry and flip the bit.

A palette write in the same cycle as a pixel catches a write-through bypass. An idle gap catches an output that strobes or changes without a pixel.

// File: rtl/gray_pwm.sv
module gray_pwm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  depth,
  input  logic [3:0]  frame_phase,
  input  logic        pix_valid,
  input  logic [3:0]  pix_code,
  input  logic [3:0]  pix_col,
  output logic        out_valid,
  output logic        out_bit
);

  localparam logic [31:0] PAL_LO_INIT = 32'h7654_3210;
  localparam logic [31:0] PAL_HI_INIT = 32'hFEDC_BA98;

  logic [31:0] pal_lo, pal_hi;
  logic [3:0]  code_m, lvl, lvl_q, phase;
  logic [31:0] word;
  logic [4:0]  cnt;
  logic [8:0]  prod;
  logic [5:0]  acc;
  logic        on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_lo <= PAL_LO_INIT;
      pal_hi <= PAL_HI_INIT;
    end else if (reg_we) begin
      if (reg_sel) pal_hi <= reg_wdata;
      else         pal_lo <= reg_wdata;
    end
  end

  assign code_m = (depth == 2'd0) ? {3'b000, pix_code[0]} :
                  (depth == 2'd1) ? {2'b00, pix_code[1:0]} : pix_code;
  assign word   = code_m[3] ? pal_hi : pal_lo;
  assign lvl    = word[{code_m[2:0], 2'b00} +: 4];

  always_comb begin
    if (lvl == 4'd0)       cnt = 5'd0;
    else if (lvl == 4'd15) cnt = 5'd16;
    else if (lvl[3])       cnt = {1'b0, lvl} - 5'd1;
    else                   cnt = {1'b0, lvl};
  end

  assign phase = frame_phase + pix_col;
  assign prod  = {5'b0, phase} * {4'b0, cnt};
  assign acc   = {2'b00, prod[3:0]} + {1'b0, cnt};
  assign on    = |acc[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      lvl_q     <= 4'd0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) begin
        out_bit <= on;
        lvl_q   <= lvl;
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && $stable(out_bit)));

  assert_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lvl_q == 4'd0) |-> !out_bit);

  assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lvl_q == 4'd15) |-> out_bit);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (pal_lo == $past(reg_wdata)));

endmodule

// File: tb/test_gray_pwm.sv
module test_gray_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  depth = 2'd2;
  logic [3:0]  frame_phase = '0;
  logic        pix_valid = 1'b0;
  logic [3:0]  pix_code = '0, pix_col = '0;
  logic        out_valid, out_bit;

  gray_pwm i_gray_pwm (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit    q_exp[$];
  string q_req[$];
  logic [31:0] m_lo = 32'h7654_3210, m_hi = 32'hFEDC_BA98;

  function automatic int level_of(input logic [3:0] code, input logic [1:0] dep);
    int n;
    logic [31:0] w;
    n = (dep == 2'd0) ? code % 2 : (dep == 2'd1) ? code % 4 : code;
    w = (n >= 8) ? m_hi : m_lo;
    return (w >> (4 * (n % 8))) & 15;
  endfunction

  function automatic bit expect_bit(input int lv, input int ph);
    int c;
    c = (lv == 0) ? 0 : (lv == 15) ? 16 : (lv <= 7) ? lv : lv - 1;
    return (((ph * c) % 16) + c) >= 16;
  endfunction

  task automatic px(input logic [3:0] code, input logic [3:0] col,
                    input logic [3:0] ph, input logic [1:0] dep, input string req);
    @(negedge clk);
    reg_we = 1'b0; pix_valid = 1'b1; pix_code = code; pix_col = col;
    frame_phase = ph; depth = dep;
    q_exp.push_back(expect_bit(level_of(code, dep), (int'(ph) + int'(col)) % 16));
    q_req.push_back(req);
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    pix_valid = 1'b0; reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    if (sel) m_hi = data; else m_lo = data;
  endtask

  task automatic wrpx(input logic sel, input logic [31:0] data, input logic [3:0] code,
                      input logic [3:0] ph);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    pix_valid = 1'b1; pix_code = code; pix_col = 4'd0; frame_phase = ph; depth = 2'd2;
    q_exp.push_back(expect_bit(level_of(code, 2'd2), int'(ph)));
    q_req.push_back("R8");
    if (sel) m_hi = data; else m_lo = data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_we = 1'b0; pix_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R7: out_valid=1 with no pixel pending (actual 1, expected 0)");
      end else begin
        bit e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        if (out_bit !== e) begin
          errors++;
          $display("FAIL %s: out_bit actual %0b expected %0b", r, out_bit, e);
        end
      end
    end
  end

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit held;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_bit !== 1'b0) begin
      errors++;
      $display("FAIL R3: reset outputs actual %0b%0b expected 00", out_valid, out_bit);
    end
    rst_n = 1'b1;
    idle(2);

    // R3/R4/R5/R6: identity palette, every level through every phase
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 16; p++)
        px(4'(c), 4'd0, 4'(p), 2'd2,
           (c == 0 || c == 15) ? "R4" : (c == 7 || c == 8) ? "R5" : "R3/R6");
    idle(2);

    // R6: column offset on a fixed frame phase
    for (int col = 0; col < 16; col++) px(4'd5, 4'(col), 4'd3, 2'd2, "R6");
    for (int col = 0; col < 16; col++) px(4'd11, 4'(col), 4'd9, 2'd3, "R6");
    idle(2);

    // R1: reverse video through an inverted palette
    wr(1'b0, ~32'h7654_3210);
    wr(1'b1, ~32'hFEDC_BA98);
    for (int c = 0; c < 16; c++) px(4'(c), 4'd2, 4'd5, 2'd2, "R1");
    idle(1);

    // R2: masked code bits select low entries only
    for (int p = 0; p < 16; p++) px(4'hE, 4'd0, 4'(p), 2'd0, "R2");
    for (int p = 0; p < 16; p++) px(4'hD, 4'd0, 4'(p), 2'd0, "R2");
    for (int p = 0; p < 16; p++) px(4'hA, 4'd1, 4'(p), 2'd1, "R2");
    for (int p = 0; p < 16; p++) px(4'h7, 4'd0, 4'(p), 2'd1, "R2");
    idle(2);

    // R8: same-cycle write keeps the old entry, next pixel sees the new one
    wrpx(1'b0, 32'h0000_0000, 4'd0, 4'd6);
    px(4'd0, 4'd0, 4'd6, 2'd2, "R8");
    wrpx(1'b1, 32'hFFFF_FFFF, 4'd9, 4'd0);
    px(4'd9, 4'd0, 4'd0, 2'd2, "R8");
    idle(3);

    // R9: idle cycles keep the bit and give no strobe
    px(4'd15, 4'd0, 4'd0, 2'd2, "R9");
    idle(1);
    @(negedge clk);
    held = out_bit;
    idle(3);
    checks++;
    if (out_valid !== 1'b0 || out_bit !== held) begin
      errors++;
      $display("FAIL R9: idle valid/bit actual %0b/%0b expected 0/%0b", out_valid, out_bit, held);
    end

    idle(3);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R7: pending results actual %0d expected 0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule